// File: doc/BRIEF.md
# Serial Two-Wire Memory Target

This block is a byte-wide memory that answers as a target on a two-wire I2C bus. A fast system clock oversamples the clock and data lines through two-flop synchronisers, and the block finds START and STOP conditions by watching for data edges while the clock is high. The first byte after a START selects the target. It is matched against a fixed type nibble and three chip-enable inputs. Its last bit chooses read or write. A write select is followed by a 16-bit address, high byte first. Only the bits that fit the array are kept.

Data bytes of a write are collected in a page buffer of 32 entries. The column index wraps inside the current row. The bytes reach the array only if the master ends the transfer with a STOP directly after a data acknowledge. The array is then updated during a busy window of a parameterised length. During that window the target stays off the bus. A write-control input that is seen high anywhere between START and the end of the address phase makes the target refuse every data byte. Reads ignore write-control. A read returns bytes from a running address counter. The master acknowledges each byte to ask for the next one, and a no-acknowledge ends the read.

The data line is never driven high. The block has one output that, when set, pulls it low.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset the data line is released, the address counter is 0, and every array byte reads FFh.
- R2: A select byte whose bits 7..4 are 1010 and whose bits 3..1 equal chip_en_i[2:0] is acknowledged (data line low during the 9th clock). Any other select byte gets no acknowledge, and the target ignores all further bytes until the next START.
- R3: START is a falling data edge while the clock is high, and STOP is a rising data edge while the clock is high. Bits are taken on the rising clock edge. The target changes the data line only while the clock is low.
- R4: After a write select, two address bytes (high byte first) are each acknowledged. Address bits at and above ADDR_W are ignored.
- R5: A single data byte written and committed can be read back at its address.
- R6: In a multi-byte write, only the low 5 address bits advance after each byte, so the bytes wrap inside the same 32-byte row. Bytes outside that row are left unchanged.
- R7: If write-control is high at any time from START to the end of the second address byte, the select and address bytes are still acknowledged. Every data byte then gets no acknowledge, no write cycle starts, and the array is unchanged.
- R8: Buffered data is written only by a STOP in the slot right after a data-byte acknowledge. A repeated START or a STOP anywhere else drops it, and no busy window starts.
- R9: For WR_CYCLES clocks after a committing STOP, the target acknowledges nothing (not even its own select) and never drives the data line. After that window it answers again.
- R10: After a write, the address counter points to the byte that follows the last byte written.
- R11: Reads do not depend on write-control. The address counter advances by one per byte sent and wraps from the top address to 0.
- R12: After each byte it sends, the target samples the 9th bit. A master acknowledge makes it send the next byte. A no-acknowledge makes it release the line and ignore traffic until the next START.
- R13: A write select with an address, followed by a repeated START and a read select, returns the byte at that address (random read). A read select alone returns the byte at the current counter (current read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When 1, the target pulls the data line low |
| chip_en_i | input | 3 | Chip-enable value compared with select bits 3..1 |
| wr_ctrl_i | input | 1 | Write inhibit, active high |

## Verification
The hardest state to reach is the busy window. The poll has to arrive while the array is still being updated: a START and a select byte must fall inside WR_CYCLES clocks of the committing STOP. To get there, the bench sets a short WR_CYCLES and sends the poll straight after the STOP, then waits out the window and polls again. A second hard case is a write that must be dropped, such as a repeated START after an acknowledged data byte or a write-control pulse during one address byte only. For these, the bench polls at once to show that no busy window began, and then reads the address back.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } bus_st_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_DATA
  } byte_kind_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges only count while the clock is high on both samples
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_page_buf.sv
module i2c_page_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) slot_q[wr_idx_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (clr_i)   valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  assign rd_data_o  = slot_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];

  // R6
  wr_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !clr_i);
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_BYTES  = 32,
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] chip_en_i,
  input  logic       wr_ctrl_i
);
  import i2c_mem_pkg::*;

  localparam int PG_W     = $clog2(PAGE_BYTES);
  localparam int ROW_W    = ADDR_W - PG_W;
  localparam int HI_W     = ADDR_W - 8;
  localparam int BUSY_CYC = (WR_CYCLES > PAGE_BYTES) ? WR_CYCLES : PAGE_BYTES + 1;
  localparam int BC_W     = $clog2(BUSY_CYC + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  bus_st_e            st;
  byte_kind_e         kind;
  logic [3:0]         bit_cnt;
  logic [7:0]         rx_sh, tx_sh;
  logic               go_tx, mack_ok, sda_oe;
  logic [HI_W-1:0]    addr_hi;
  logic [ADDR_W-1:0]  addr_cnt, full_addr;
  logic [ROW_W-1:0]   row;
  logic [PG_W-1:0]    wr_low, last_low;
  logic               have_data, wp_flag;
  logic               busy;
  logic [BC_W-1:0]    busy_cnt;
  logic [PG_W:0]      drain_idx;
  logic [7:0]         rd_data, buf_data;
  logic               buf_valid, buf_wr, buf_clr, mem_we, commit, sel_hit, byte_end;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  assign full_addr = {addr_hi, rx_sh};
  assign sel_hit   = (rx_sh[7:4] == DEV_TYPE) && (rx_sh[3:1] == chip_en_i);
  assign byte_end  = (st == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  // commit only in the slot right after a data acknowledge
  assign commit    = stop_det && !busy && (st == ST_RX) && (kind == K_DATA) &&
                     (bit_cnt == 4'd1) && have_data && !wp_flag;
  assign buf_wr    = !busy && !start_det && !stop_det && byte_end &&
                     (kind == K_DATA) && !wp_flag;
  assign buf_clr   = (start_det && !busy) || (busy && busy_cnt == '0);
  assign mem_we    = busy && !drain_idx[PG_W] && buf_valid;

  i2c_page_buf #(.DATA_W(8), .DEPTH(PAGE_BYTES)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .wr_en_i    (buf_wr),
    .wr_idx_i   (wr_low),
    .wr_data_i  (rx_sh),
    .rd_idx_i   (drain_idx[PG_W-1:0]),
    .rd_data_o  (buf_data),
    .rd_valid_o (buf_valid)
  );

  i2c_mem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i ({row, drain_idx[PG_W-1:0]}),
    .wdata_i (buf_data),
    .raddr_i (addr_cnt),
    .rdata_o (rd_data)
  );

  // internal programming window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy      <= 1'b0;
      busy_cnt  <= '0;
      drain_idx <= '0;
    end else if (commit) begin
      busy      <= 1'b1;
      busy_cnt  <= BC_W'(BUSY_CYC - 1);
      drain_idx <= '0;
    end else if (busy) begin
      if (!drain_idx[PG_W]) drain_idx <= drain_idx + 1'b1;
      if (busy_cnt == '0) busy <= 1'b0;
      else                busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      kind      <= K_DEV;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      go_tx     <= 1'b0;
      mack_ok   <= 1'b0;
      sda_oe    <= 1'b0;
      addr_hi   <= '0;
      addr_cnt  <= '0;
      row       <= '0;
      wr_low    <= '0;
      last_low  <= '0;
      have_data <= 1'b0;
      wp_flag   <= 1'b0;
    end else if (busy) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st        <= ST_RX;
      kind      <= K_DEV;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      have_data <= 1'b0;
      wp_flag   <= wr_ctrl_i;
    end else if (stop_det) begin
      if (commit) addr_cnt <= {row, last_low} + 1'b1;
      have_data <= 1'b0;
      st        <= ST_IDLE;
      sda_oe    <= 1'b0;
    end else begin
      if (st != ST_IDLE && kind != K_DATA && wr_ctrl_i) wp_flag <= 1'b1;
      case (st)
        ST_RX: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            rx_sh   <= {rx_sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_end) begin
            go_tx  <= 1'b0;
            st     <= ST_ACK;
            sda_oe <= 1'b1;
            case (kind)
              K_DEV: begin
                if (sel_hit) begin
                  go_tx <= rx_sh[0];
                  kind  <= K_AHI;
                end else begin
                  st     <= ST_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              K_AHI: begin
                addr_hi <= rx_sh[HI_W-1:0];
                kind    <= K_ALO;
              end
              K_ALO: begin
                addr_cnt <= full_addr;
                row      <= full_addr[ADDR_W-1:PG_W];
                wr_low   <= full_addr[PG_W-1:0];
                kind     <= K_DATA;
              end
              default: begin
                if (wp_flag) begin
                  sda_oe <= 1'b0;
                end else begin
                  wr_low    <= wr_low + 1'b1;
                  last_low  <= wr_low;
                  have_data <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (go_tx) begin
              tx_sh    <= rd_data;
              addr_cnt <= addr_cnt + 1'b1;
              sda_oe   <= ~rd_data[7];
              st       <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              sda_oe  <= ~tx_sh[6];
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_ok) begin
              tx_sh    <= rd_data;
              addr_cnt <= addr_cnt + 1'b1;
              sda_oe   <= ~rd_data[7];
              bit_cnt  <= '0;
              st       <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe;

  // R9
  busy_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  // R3
  drive_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_s);

  // R8
  commit_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));

  // R7
  wp_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && byte_end && kind == K_DATA && wp_flag) |=> !sda_oe_o);

  // R2
  sel_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && byte_end && kind == K_DEV && !sel_hit) |=> (st == ST_IDLE && !sda_oe_o));
endmodule

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  localparam int HALF = 10;
  localparam int WR   = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       wc = 1'b0;
  logic [2:0] ce = 3'b101;
  logic       sda_oe;
  logic       sda_w;
  int         n_chk = 0;
  int         n_bad = 0;
  int         r3_viol = 0;
  bit         done = 1'b0;
  logic [7:0] wdat [8];
  logic [7:0] rdat [8];

  assign sda_w = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  i2c_mem_target #(.WR_CYCLES(WR)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_w),
    .sda_oe_o  (sda_oe),
    .chip_en_i (ce),
    .wr_ctrl_i (wc)
  );

  // R3: target output must stay put while the clock line is high
  logic scl_d = 1'b1, oe_d = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && scl_d && sda_oe != oe_d) r3_viol++;
    scl_d <= scl;
    oe_d  <= sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dsel(input logic rd);
    return {4'hA, ce, rd};
  endfunction

  task automatic bus_start();
    m_low = 1'b0; clk_n(2);
    scl = 1'b1;   clk_n(HALF);
    m_low = 1'b1; clk_n(HALF);
    scl = 1'b0;   clk_n(2);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; clk_n(2);
    scl = 1'b1;   clk_n(HALF);
    m_low = 1'b0; clk_n(HALF);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; clk_n(HALF);
      scl = 1'b1;    clk_n(HALF);
      scl = 1'b0;    clk_n(2);
    end
    m_low = 1'b0; clk_n(HALF);
    scl = 1'b1;   clk_n(HALF/2);
    ack = ~sda_w; clk_n(HALF - HALF/2);
    scl = 1'b0;   clk_n(2);
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      clk_n(HALF);
      scl = 1'b1; clk_n(HALF/2);
      b[i] = sda_w; clk_n(HALF - HALF/2);
      scl = 1'b0;
    end
    clk_n(2);
    m_low = mack; clk_n(HALF);
    scl = 1'b1;   clk_n(HALF);
    scl = 1'b0;   clk_n(2);
    m_low = 1'b0;
  endtask

  task automatic wait_write();
    clk_n(WR + 40);
  endtask

  task automatic mem_write(input logic [15:0] a, input int n, input string req);
    logic ak;
    bus_start();
    put_byte(dsel(1'b0), ak); chk(req, ak, 1);
    put_byte(a[15:8], ak);    chk(req, ak, 1);
    put_byte(a[7:0], ak);     chk(req, ak, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(wdat[i], ak);  chk(req, ak, 1);
    end
    bus_stop();
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string req);
    logic ak;
    logic [7:0] b;
    bus_start();
    put_byte(dsel(1'b0), ak); chk(req, ak, 1);
    put_byte(a[15:8], ak);    chk(req, ak, 1);
    put_byte(a[7:0], ak);     chk(req, ak, 1);
    bus_start();
    put_byte(dsel(1'b1), ak); chk(req, ak, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, b);
      rdat[i] = b;
    end
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string req);
    logic ak;
    logic [7:0] b;
    bus_start();
    put_byte(dsel(1'b1), ak); chk(req, ak, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, b);
      rdat[i] = b;
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 line released", sda_oe, 0);
    cur_read(1, "R13 current read");
    chk("R1 erased byte", rdat[0], 8'hFF);
  endtask

  task automatic t_select();
    logic ak;
    bus_start();
    put_byte({4'hA, 3'b100, 1'b0}, ak); chk("R2 ce mismatch", ak, 0);
    put_byte(8'h00, ak);                chk("R2 ignored after miss", ak, 0);
    bus_stop();
    bus_start();
    put_byte({4'hB, ce, 1'b0}, ak);     chk("R2 type mismatch", ak, 0);
    bus_stop();
    bus_start();
    put_byte(dsel(1'b0), ak);           chk("R3 select sampled", ak, 1);
    bus_stop();
  endtask

  task automatic t_byte_and_poll();
    logic ak;
    wdat[0] = 8'h5C;
    mem_write(16'h0023, 1, "R5");
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R9 poll while busy", ak, 0);
    bus_stop();
    wait_write();
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R9 poll after window", ak, 1);
    bus_stop();
    rand_read(16'h0023, 1, "R13");
    chk("R5 byte readback", rdat[0], 8'h5C);
    wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
    mem_write(16'h0020, 3, "R10");
    wait_write();
    cur_read(1, "R10");
    chk("R10 counter after write", rdat[0], 8'h5C);
    rand_read(16'h0020, 3, "R5");
    chk("R5 page byte0", rdat[0], 8'h11);
    chk("R5 page byte1", rdat[1], 8'h22);
    chk("R5 page byte2", rdat[2], 8'h33);
  endtask

  task automatic t_page_wrap();
    wdat[0] = 8'hD0; wdat[1] = 8'hD1; wdat[2] = 8'hD2; wdat[3] = 8'hD3;
    mem_write(16'h005E, 4, "R6");
    wait_write();
    rand_read(16'h005E, 3, "R12");
    chk("R6 row end -2", rdat[0], 8'hD0);
    chk("R6 row end -1", rdat[1], 8'hD1);
    chk("R6 next row untouched", rdat[2], 8'hFF);
    rand_read(16'h0040, 2, "R6");
    chk("R6 wrapped to row start", rdat[0], 8'hD2);
    chk("R6 wrapped +1", rdat[1], 8'hD3);
  endtask

  task automatic t_wr_ctrl();
    logic ak;
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R7 select acked", ak, 1);
    wc = 1'b1;
    put_byte(8'h01, ak);      chk("R7 addr hi acked", ak, 1);
    wc = 1'b0;
    put_byte(8'h00, ak);      chk("R7 addr lo acked", ak, 1);
    put_byte(8'h99, ak);      chk("R7 data refused", ak, 0);
    bus_stop();
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R7 no write cycle", ak, 1);
    bus_stop();
    rand_read(16'h0100, 1, "R7");
    chk("R7 memory unchanged", rdat[0], 8'hFF);
  endtask

  task automatic t_discard();
    logic ak;
    logic [7:0] b;
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R8", ak, 1);
    put_byte(8'h02, ak);      chk("R8", ak, 1);
    put_byte(8'h00, ak);      chk("R8", ak, 1);
    put_byte(8'h42, ak);      chk("R8 data acked", ak, 1);
    bus_start();
    put_byte(dsel(1'b1), ak); chk("R13 random read select", ak, 1);
    get_byte(1'b0, b);
    chk("R8 dropped write", b, 8'hFF);
    bus_stop();
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R8 no busy window", ak, 1);
    bus_stop();
  endtask

  task automatic t_upper_bits();
    wdat[0] = 8'h6B;
    mem_write(16'hF123, 1, "R4");
    wait_write();
    rand_read(16'h0123, 1, "R4");
    chk("R4 upper bits ignored", rdat[0], 8'h6B);
  endtask

  task automatic t_top_wrap();
    wdat[0] = 8'hE1;
    mem_write(16'h0FFF, 1, "R11");
    wait_write();
    wdat[0] = 8'hE2;
    mem_write(16'h0000, 1, "R11");
    wait_write();
    wc = 1'b1;
    rand_read(16'h0FFF, 2, "R11");
    chk("R11 top byte", rdat[0], 8'hE1);
    chk("R11 wrap to zero", rdat[1], 8'hE2);
    cur_read(1, "R11");
    wc = 1'b0;
    chk("R11 counter +1", rdat[0], 8'hFF);
  endtask

  task automatic t_standby();
    logic ak;
    logic [7:0] b;
    bus_start();
    put_byte(dsel(1'b1), ak); chk("R12", ak, 1);
    get_byte(1'b0, b);
    put_byte(dsel(1'b0), ak); chk("R12 standby after nack", ak, 0);
    bus_stop();
    bus_start();
    put_byte(dsel(1'b0), ak); chk("R12 wakes on START", ak, 1);
    bus_stop();
  endtask

  initial begin
    clk_n(5);
    rst_n = 1'b1;
    clk_n(5);
    t_reset();
    t_select();
    t_byte_and_poll();
    t_page_wrap();
    t_wr_ctrl();
    t_discard();
    t_upper_bits();
    t_top_wrap();
    t_standby();
    chk("R3 output stable while clock high", r3_viol, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule